// File: doc/BRIEF.md
# Panel Raster Timing Generator

This block drives the raster timing of a TFT display panel. It keeps a horizontal counter clocked by the pixel clock and a line counter. From them it derives the horizontal sync, vertical sync and data-enable signals, the position of the current pixel inside the visible window, and a strobe that asks the pixel source for the next pixel. Software sets every edge of the raster through a small register write port. Each timing register holds two absolute counter values: the point where a signal becomes active and the point where it stops being active.

A mode field selects either a plain parallel panel or an 8-bit serial panel. A serial panel receives each colour component on a separate clock, so every visible pixel lasts three pixel clocks, and the block stretches the visible part of each line to match. Each output has its own polarity bit.

A control write starts the raster. A stop request is held until the frame in progress ends. New timing values written while the raster runs are held in staging storage and take effect at the next frame boundary, so a frame is never built from mixed settings.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset all outputs are low (hsync, vsync, de, pixReq, frameDone, pclkInvert, pixX = 0, pixY = 0), and they stay at their idle levels until the raster is started.
- R2: The write address selects a register: 0 config, 1 horizontal sync, 2 vertical sync, 3 totals, 4 horizontal window, 5 vertical window, 6 control. Each timing register carries its start value in bits 31:16 and its end value in bits 15:0. In the totals register, bits 31:16 hold the horizontal total and bits 15:0 hold the vertical total.
- R3: The horizontal sync is active when start <= horizontal count < end. The vertical sync is active when start <= line count < end.
- R4: The horizontal count runs from 0 to total-1 and then wraps to 0, which advances the line count. The line count wraps to 0 after total-1. A parallel frame therefore lasts hTotal*vTotal clocks.
- R5: de is active when the horizontal count lies in [hStart, hEnd) and the line count lies in [vStart, vEnd). While de is active, pixX = count - hStart and pixY = line - vStart; otherwise both are 0. In parallel mode pixReq equals de before polarity is applied.
- R6: When config bits 3:0 equal 0xC (8-bit serial), the horizontal count holds for three clocks at each position inside the horizontal window. A line then lasts hTotal + 2*(hEnd-hStart) clocks, and pixReq is raised only on the first of the three clocks of each visible pixel.
- R7: Config bit 11 inverts hsync, bit 8 inverts vsync and bit 9 inverts de. Bit 10 is presented on pclkInvert. Polarity also applies to the idle levels.
- R8: A control write with bit 3 set starts the raster at count 0 and line 0 in the next cycle, and it cancels any pending stop request. The raster then keeps running through the frame end.
- R9: frameDone is high on the last clock of every frame. A control write with bit 4 set (bit 3 clear) stops the raster only after the clock on which frameDone is high. The outputs then return to their idle levels.
- R10: Timing and config writes made while the raster runs do not change the frame in progress. They take effect from the first clock of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pclkInvert | output | 1 | Selected pixel clock edge for the panel |
| pixX | output | 16 | Column of the current visible pixel |
| pixY | output | 16 | Row of the current visible pixel |
| pixReq | output | 1 | Request for the next pixel |
| frameDone | output | 1 | High on the last clock of a frame |

## Verification
The assertions assume that software programs each window with start no greater than end and within a non-zero total, and that it writes the timing registers before the start command rather than in the same cycle. The stimulus keeps to these limits. It programs only consistent rasters, writes all timing registers before enabling, and places every write made while running well inside a frame, never on its last clock. The assertions on counter bounds and serial pixel spacing hold only for such programming.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int FW = 16;            // width of one start/end field
  localparam int AW = 3;             // register address width
  localparam int DW = 2 * FW;        // write data width

  localparam logic [AW-1:0] A_CFG   = 3'd0;
  localparam logic [AW-1:0] A_HSYNC = 3'd1;
  localparam logic [AW-1:0] A_VSYNC = 3'd2;
  localparam logic [AW-1:0] A_TOTAL = 3'd3;
  localparam logic [AW-1:0] A_HWIN  = 3'd4;
  localparam logic [AW-1:0] A_VWIN  = 3'd5;
  localparam logic [AW-1:0] A_CTRL  = 3'd6;

  localparam logic [3:0] MODE_SERIAL = 4'hC;
  localparam int CFG_INV_V    = 8;
  localparam int CFG_INV_DE   = 9;
  localparam int CFG_INV_PCLK = 10;
  localparam int CFG_INV_H    = 11;
  localparam int CTRL_EN      = 3;
  localparam int CTRL_DIS     = 4;
  localparam int SER_PHASES   = 3;   // clocks per serial pixel

  typedef struct packed {
    logic [FW-1:0] hsS, hsE, vsS, vsE;
    logic [FW-1:0] hTot, vTot;
    logic [FW-1:0] hwS, hwE, vwS, vwE;
    logic [3:0]    mode;
    logic          invH, invV, invDe, invPclk;
  } timing_t;

  typedef struct packed {
    logic run;     // counters advance
    logic serial;  // stretch visible pixels
  } strobe_t;
endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          frameEnd,
  output strobe_t       stb,
  output timing_t       tim,
  output logic          pclkInvert
);
  timing_t stageQ, activeQ;
  logic running, disPend, commit, ctrlWr;
  logic unusedBits;

  assign ctrlWr = wrEn && (wrAddr == A_CTRL);
  assign commit = !running || frameEnd;
  assign unusedBits = ^{wrData[DW-1:12], wrData[7:4], wrData[2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ  <= '0;
      activeQ <= '0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          A_CFG: begin
            stageQ.mode    <= wrData[3:0];
            stageQ.invV    <= wrData[CFG_INV_V];
            stageQ.invDe   <= wrData[CFG_INV_DE];
            stageQ.invPclk <= wrData[CFG_INV_PCLK];
            stageQ.invH    <= wrData[CFG_INV_H];
          end
          A_HSYNC: {stageQ.hsS, stageQ.hsE} <= wrData;
          A_VSYNC: {stageQ.vsS, stageQ.vsE} <= wrData;
          A_TOTAL: {stageQ.hTot, stageQ.vTot} <= wrData;
          A_HWIN:  {stageQ.hwS, stageQ.hwE} <= wrData;
          A_VWIN:  {stageQ.vwS, stageQ.vwE} <= wrData;
          default: ;
        endcase
      end
      if (commit) activeQ <= stageQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      disPend <= 1'b0;
    end else begin
      if (frameEnd && disPend) begin
        running <= 1'b0;
        disPend <= 1'b0;
      end
      if (ctrlWr) begin
        if (wrData[CTRL_EN]) begin
          running <= 1'b1;
          disPend <= 1'b0;
        end else if (wrData[CTRL_DIS] && running) begin
          disPend <= 1'b1;
        end
      end
    end
  end

  assign stb.run    = running;
  assign stb.serial = (activeQ.mode == MODE_SERIAL);
  assign tim        = activeQ;
  assign pclkInvert = activeQ.invPclk;

  // R9: the raster only stops right after a frame's last clock
  a_r9_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(frameEnd));

  // R10: live timing is frozen inside a running frame
  a_r10_hold_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(frameEnd)) |-> $stable(activeQ));

  // R8: a start command leaves the raster running with no stop pending
  a_r8_start_clears_stop: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[CTRL_EN]) |=> (running && !disPend));
endmodule

// File: rtl/ptg_datapath.sv
module ptg_datapath
  import ptg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  timing_t       tim,
  output logic          frameEnd,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] pixX,
  output logic [FW-1:0] pixY,
  output logic          pixReq
);
  localparam int PW = $clog2(SER_PHASES);
  localparam logic [PW-1:0] PH_LAST = PW'(SER_PHASES - 1);

  logic [FW-1:0] hCnt, vCnt;
  logic [PW-1:0] phase;
  logic hAct, vAct, hsRaw, vsRaw, deRaw, serialAct, advance, hLast, vLast;
  logic unusedTim;

  assign unusedTim = ^{tim.mode, tim.invPclk};

  always_comb begin
    hAct      = stb.run && (hCnt >= tim.hwS) && (hCnt < tim.hwE);
    vAct      = stb.run && (vCnt >= tim.vwS) && (vCnt < tim.vwE);
    hsRaw     = stb.run && (hCnt >= tim.hsS) && (hCnt < tim.hsE);
    vsRaw     = stb.run && (vCnt >= tim.vsS) && (vCnt < tim.vsE);
    deRaw     = hAct && vAct;
    serialAct = stb.serial && hAct;
    advance   = !serialAct || (phase == PH_LAST);
    hLast     = (hCnt == tim.hTot - FW'(1));
    vLast     = (vCnt == tim.vTot - FW'(1));
  end

  assign frameEnd = stb.run && advance && hLast && vLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt  <= '0;
      vCnt  <= '0;
      phase <= '0;
    end else if (!stb.run) begin
      hCnt  <= '0;
      vCnt  <= '0;
      phase <= '0;
    end else begin
      phase <= (serialAct && phase != PH_LAST) ? phase + PW'(1) : '0;
      if (advance) begin
        if (hLast) begin
          hCnt <= '0;
          vCnt <= vLast ? '0 : vCnt + FW'(1);
        end else begin
          hCnt <= hCnt + FW'(1);
        end
      end
    end
  end

  assign hsync  = hsRaw ^ tim.invH;
  assign vsync  = vsRaw ^ tim.invV;
  assign de     = deRaw ^ tim.invDe;
  assign pixX   = deRaw ? hCnt - tim.hwS : '0;
  assign pixY   = deRaw ? vCnt - tim.vwS : '0;
  assign pixReq = deRaw && (phase == '0);

  // R4: counters never reach their programmed totals
  a_r4_h_below_total: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && tim.hTot != '0) |-> (hCnt < tim.hTot));
  a_r4_v_below_total: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && tim.vTot != '0) |-> (vCnt < tim.vTot));

  // R6: serial pixels are requested at most once per three clocks
  a_r6_serial_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (pixReq && stb.serial) |=> !pixReq);

  // R9: the cycle after a frame end starts again at the origin
  a_r9_wrap_to_origin: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (hCnt == '0 && vCnt == '0));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import ptg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclkInvert,
  output logic [FW-1:0] pixX,
  output logic [FW-1:0] pixY,
  output logic          pixReq,
  output logic          frameDone
);
  strobe_t stb;
  timing_t tim;
  logic    frameEnd;

  ptg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameEnd(frameEnd), .stb(stb), .tim(tim), .pclkInvert(pclkInvert)
  );

  ptg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tim(tim), .frameEnd(frameEnd),
    .hsync(hsync), .vsync(vsync), .de(de), .pixX(pixX), .pixY(pixY),
    .pixReq(pixReq)
  );

  assign frameDone = frameEnd;
endmodule

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;
  import ptg_pkg::*;

  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 200000;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic hsync, vsync, de, pclkInvert, pixReq, frameDone;
  logic [FW-1:0] pixX, pixY;

  panel_timing_gen u_panel_timing_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsync(hsync), .vsync(vsync), .de(de), .pclkInvert(pclkInvert),
    .pixX(pixX), .pixY(pixY), .pixReq(pixReq), .frameDone(frameDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int hsS, hsE, vsS, vsE, hT, vT, hwS, hwE, vwS, vwE;
    bit serial, iH, iV, iD, iP;
  } tp_t;

  typedef struct packed {
    logic hs, vs, de, preq, fd;
    logic [FW-1:0] px, py;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  int vectors = 0, miscompares = 0;
  int mh = 0, mv = 0, mph = 0;

  function automatic int frameLen(tp_t p);
    return p.serial ? (p.hT + 2 * (p.hwE - p.hwS)) * p.vT : p.hT * p.vT;
  endfunction

  task automatic modelReset();
    mh = 0; mv = 0; mph = 0;
  endtask

  // expected raster from the requirements, one item per clock
  task automatic pushCycles(tp_t p, int n, string tag);
    for (int k = 0; k < n; k++) begin
      bit hA, vA, deR, sA, adv;
      item_t it;
      hA  = (mh >= p.hwS) && (mh < p.hwE);
      vA  = (mv >= p.vwS) && (mv < p.vwE);
      deR = hA && vA;
      sA  = p.serial && hA;
      adv = !sA || (mph == 2);
      it.hs   = ((mh >= p.hsS) && (mh < p.hsE)) ^ p.iH;
      it.vs   = ((mv >= p.vsS) && (mv < p.vsE)) ^ p.iV;
      it.de   = deR ^ p.iD;
      it.preq = deR && (mph == 0);
      it.fd   = adv && (mh == p.hT - 1) && (mv == p.vT - 1);
      it.px   = deR ? FW'(mh - p.hwS) : '0;
      it.py   = deR ? FW'(mv - p.vwS) : '0;
      expQ.push_back(it);
      tagQ.push_back(tag);
      mph = (sA && mph != 2) ? mph + 1 : 0;
      if (adv) begin
        if (mh == p.hT - 1) begin
          mh = 0;
          mv = (mv == p.vT - 1) ? 0 : mv + 1;
        end else begin
          mh = mh + 1;
        end
      end
    end
  endtask

  task automatic pushIdle(tp_t p, int n, string tag);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it = '0;
      it.hs = p.iH; it.vs = p.iV; it.de = p.iD;
      expQ.push_back(it);
      tagQ.push_back(tag);
    end
  endtask

  task automatic writeReg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic programTiming(tp_t p);
    writeReg(A_CFG, {20'b0, p.iH, p.iP, p.iD, p.iV, 4'b0,
                     (p.serial ? 4'hC : 4'h0)});
    writeReg(A_HSYNC, {FW'(p.hsS), FW'(p.hsE)});
    writeReg(A_VSYNC, {FW'(p.vsS), FW'(p.vsE)});
    writeReg(A_TOTAL, {FW'(p.hT),  FW'(p.vT)});
    writeReg(A_HWIN,  {FW'(p.hwS), FW'(p.hwE)});
    writeReg(A_VWIN,  {FW'(p.vwS), FW'(p.vwE)});
  endtask

  task automatic waitQueueAtMost(int n);
    while (expQ.size() > n) @(negedge clk);
  endtask

  task automatic checkNow(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // monitor: compares one expected item per clock
  always @(negedge clk) begin
    item_t e, a;
    string t;
    if (rstN && expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a.hs = hsync; a.vs = vsync; a.de = de; a.preq = pixReq;
      a.fd = frameDone; a.px = pixX; a.py = pixY;
      vectors++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s @%0t: got hs=%b vs=%b de=%b req=%b fd=%b x=%0d y=%0d, expected hs=%b vs=%b de=%b req=%b fd=%b x=%0d y=%0d",
                 t, $time, a.hs, a.vs, a.de, a.preq, a.fd, a.px, a.py,
                 e.hs, e.vs, e.de, e.preq, e.fd, e.px, e.py);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    tp_t pa, pb, ps, pr;
    pa = '{hsS:0, hsE:2, vsS:0, vsE:1, hT:12, vT:7, hwS:4, hwE:9, vwS:2, vwE:6,
           serial:0, iH:0, iV:0, iD:0, iP:0};
    pb = pa; pb.hT = 10; pb.hwS = 3; pb.hwE = 7;
    ps = '{hsS:0, hsE:1, vsS:0, vsE:1, hT:8, vT:4, hwS:3, hwE:5, vwS:1, vwE:3,
           serial:1, iH:1, iV:1, iD:1, iP:1};
    pr = '{hsS:0, hsE:1, vsS:0, vsE:1, hT:734, vT:262, hwS:141, hwE:461,
           vwS:21, vwE:261, serial:1, iH:1, iV:1, iD:0, iP:1};

    // R1: idle state during and after reset
    repeat (3) @(negedge clk);
    checkNow("R1 in reset", {51'b0, hsync, vsync, de, pixReq, frameDone,
             pclkInvert, pixX != 0, pixY != 0, 5'b0}, 64'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkNow("R1 after reset", {51'b0, hsync, vsync, de, pixReq, frameDone,
             pclkInvert, pixX != 0, pixY != 0, 5'b0}, 64'h0);

    // R2/R3/R4/R5/R9 parallel raster, then R10 update and R9 stop
    programTiming(pa);
    writeReg(A_CTRL, 32'h8);
    modelReset();
    pushCycles(pa, 2 * frameLen(pa), "R2/R3/R4/R5/R9");
    pushCycles(pa, frameLen(pa), "R10 old frame");
    pushCycles(pb, frameLen(pb), "R10 new frame");
    pushIdle(pb, 5, "R9 stopped");
    waitQueueAtMost(frameLen(pb) + 5 + frameLen(pa) - 10);
    programTiming(pb);
    waitQueueAtMost(40);
    writeReg(A_CTRL, 32'h10);
    waitQueueAtMost(0);

    // R6/R7 serial with inverted polarity; R8 restart cancels stop
    programTiming(ps);
    @(negedge clk);
    checkNow("R7 pclkInvert", {63'b0, pclkInvert}, 64'h1);
    pushIdle(ps, 2, "R7 idle polarity");
    waitQueueAtMost(0);
    writeReg(A_CTRL, 32'h8);
    modelReset();
    pushCycles(ps, frameLen(ps), "R6/R7");
    pushCycles(ps, frameLen(ps), "R6/R8");
    pushIdle(ps, 4, "R9 serial stop");
    waitQueueAtMost(2 * frameLen(ps) + 4 - 15);
    writeReg(A_CTRL, 32'h10);
    writeReg(A_CTRL, 32'h8);
    waitQueueAtMost(30);
    writeReg(A_CTRL, 32'h10);
    waitQueueAtMost(0);

    // R4/R6 wide serial raster: first two lines
    programTiming(pr);
    writeReg(A_CTRL, 32'h8);
    modelReset();
    pushCycles(pr, 2 * (pr.hT + 2 * (pr.hwE - pr.hwS)), "R4/R6 wide");
    waitQueueAtMost(0);

    // R1: reset returns everything to idle
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkNow("R1 re-reset", {51'b0, hsync, vsync, de, pixReq, frameDone,
             pclkInvert, pixX != 0, pixY != 0, 5'b0}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end
endmodule